// File: doc/BRIEF.md
# APB Write Monitor with Shadow Register Model

A passive, synthesizable bus monitor that sits beside an APB subordinate and watches every write transfer. It drives nothing on the bus. It reports three kinds of problem through sticky error flags: address or write data moving before the transfer completes, an access phase entered without a setup phase, and a read-back value that disagrees with what the writes should have left behind.

The monitor finds the commit of each write by searching for the first access cycle in which the subordinate signals ready. It does not assume that the commit falls in a fixed cycle. It counts the not-ready access cycles before that commit and reports the count. It keeps a shadow copy of the subordinate's register file. A write that completes with an error response leaves the shadow untouched, because such a write has no side effect. Per-register hit bits record which addresses have ever been the target of a completed write.

Software or a scoreboard compares read data against the shadow by presenting the value on the read-back port. A peek port returns any shadow entry combinationally.

Top module: `apb_wr_monitor`

## Requirements
- R1: A commit is a cycle with psel, penable, pwrite and pready all high. On a commit with pslverr low, the shadow entry selected by paddr bits [4:2] takes pwdata at that clock edge.
- R2: On a commit with pslverr high, the addressed shadow entry keeps its previous value.
- R3: The shadow never changes at the edge of a write access cycle in which pready is low.
- R4: The cycle after each commit, waitCntValid is high for exactly one cycle. In that cycle waitCnt holds the number of pready-low access cycles of that transfer, counted from its setup cycle. In all other cycles waitCntValid is low.
- R5: okCommitCnt increments on every commit with pslverr low. errCommitCnt increments on every commit with pslverr high. Neither counter moves in any other cycle.
- R6: notHeldErr is set when, in a write access cycle that follows a setup or wait cycle of the same write, paddr or pwdata differs from its value in the previous cycle. Clean writes never set it.
- R7: seqErr is set when psel and penable are both high and the previous cycle was neither a setup cycle (psel high, penable low) nor a not-ready access cycle.
- R8: When rbValid is high and rbData differs from the shadow entry selected by rbIdx, rbMismatchErr is set. A matching read-back leaves it low.
- R9: Bit i of hitBits is set by any commit, errored or not, whose index bits equal i. It stays clear otherwise.
- R10: notHeldErr, seqErr and rbMismatchErr stay set until a cycle with clrFlags high clears them. Active-low rstN clears all flags, counters, hit bits, the shadow and the wait report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrFlags | input | 1 | Clears the sticky error flags |
| psel | input | 1 | Observed select |
| penable | input | 1 | Observed enable |
| pwrite | input | 1 | Observed direction, high for write |
| paddr | input | ADDR_W | Observed byte address |
| pwdata | input | DATA_W | Observed write data |
| pready | input | 1 | Observed subordinate ready |
| pslverr | input | 1 | Observed error response |
| rbValid | input | 1 | Read-back compare strobe |
| rbIdx | input | IDX_W | Register index of the read-back |
| rbData | input | DATA_W | Value read back from the subordinate |
| peekIdx | input | IDX_W | Shadow entry to view |
| peekData | output | DATA_W | Contents of the viewed shadow entry |
| notHeldErr | output | 1 | Sticky flag: address or data moved mid-transfer |
| seqErr | output | 1 | Sticky flag: access without setup |
| rbMismatchErr | output | 1 | Sticky flag: read-back disagrees with shadow |
| waitCnt | output | WAIT_W | Wait cycles of the last committed transfer |
| waitCntValid | output | 1 | One-cycle pulse after each commit |
| okCommitCnt | output | CNT_W | Count of successful commits |
| errCommitCnt | output | CNT_W | Count of errored commits |
| hitBits | output | 2**IDX_W | Per-register write-hit record |

## Verification
The assertions assume the observed bus changes only between clock edges. They also assume peekIdx is either held or deliberately moved, so that a change in peekData can be blamed on the shadow. The stimulus drives every bus and control input on the falling edge. The peek index is set once per transfer and held through its setup, wait and commit cycles. Counter assertions assume no wrap within the run, and the test stays far below the counter range.

// File: rtl/apb_wmon_pkg.sv
package apb_wmon_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic xferStart;  // setup cycle of a write
    logic waitTick;   // write access cycle with ready low
    logic commitOk;   // write commit, no error response
    logic commitErr;  // write commit with error response
    logic holdCheck;  // compare address/data against previous cycle
  } monStrobes_t;

endpackage

// File: rtl/apb_wmon_ctrl.sv
module apb_wmon_ctrl
  import apb_wmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrFlags,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic        pready,
  input  logic        pslverr,
  output monStrobes_t strobes,
  output logic        seqErr
);

  logic setupNow, accessNow, commitNow;
  logic prevLive;       // previous cycle was setup or not-ready access
  logic prevWriteLive;  // same, restricted to a write
  logic seqViol;

  assign setupNow  = psel && !penable;
  assign accessNow = psel && penable;
  assign commitNow = accessNow && pwrite && pready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLive      <= 1'b0;
      prevWriteLive <= 1'b0;
    end else begin
      prevLive      <= psel && !(penable && pready);
      prevWriteLive <= psel && pwrite && !(penable && pready);
    end
  end

  assign seqViol = accessNow && !prevLive;

  always_comb begin
    strobes           = '0;
    strobes.xferStart = setupNow && pwrite;
    strobes.waitTick  = accessNow && pwrite && !pready;
    strobes.commitOk  = commitNow && !pslverr;
    strobes.commitErr = commitNow && pslverr;
    strobes.holdCheck = accessNow && pwrite && prevWriteLive;
  end

  // Sticky; a new violation takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seqErr <= 1'b0;
    else if (seqViol)  seqErr <= 1'b1;
    else if (clrFlags) seqErr <= 1'b0;
  end

endmodule

// File: rtl/apb_wmon_dp.sv
module apb_wmon_dp
  import apb_wmon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3,
  parameter int IDX_LSB = 2,
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clrFlags,
  input  monStrobes_t           strobes,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  input  logic                  rbValid,
  input  logic [IDX_W-1:0]      rbIdx,
  input  logic [DATA_W-1:0]     rbData,
  input  logic [IDX_W-1:0]      peekIdx,
  output logic [DATA_W-1:0]     peekData,
  output logic                  notHeldErr,
  output logic                  rbMismatchErr,
  output logic [WAIT_W-1:0]     waitCnt,
  output logic                  waitCntValid,
  output logic [CNT_W-1:0]      okCommitCnt,
  output logic [CNT_W-1:0]      errCommitCnt,
  output logic [(1<<IDX_W)-1:0] hitBits
);

  localparam int NUM_REGS = 1 << IDX_W;

  logic [ADDR_W-1:0] prevAddr;
  logic [DATA_W-1:0] prevData;
  logic [IDX_W-1:0]  wrIdx;
  logic [WAIT_W-1:0] waitRun;
  logic              anyCommit;
  logic              holdViol;
  logic              rbViol;
  logic [DATA_W-1:0] shadowVec [NUM_REGS];

  assign wrIdx     = paddr[IDX_LSB +: IDX_W];
  assign anyCommit = strobes.commitOk || strobes.commitErr;
  assign holdViol  = strobes.holdCheck &&
                     ((paddr != prevAddr) || (pwdata != prevData));
  assign rbViol    = rbValid && (rbData != shadowVec[rbIdx]);
  assign peekData  = shadowVec[peekIdx];

  // Previous-cycle copy of the address and data buses.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= '0;
      prevData <= '0;
    end else begin
      prevAddr <= paddr;
      prevData <= pwdata;
    end
  end

  // Wait-state counter, restarted by each setup, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitRun <= '0;
    end else if (strobes.xferStart) begin
      waitRun <= '0;
    end else if (strobes.waitTick && (waitRun != '1)) begin
      waitRun <= waitRun + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt      <= '0;
      waitCntValid <= 1'b0;
    end else begin
      waitCntValid <= anyCommit;
      if (anyCommit) waitCnt <= waitRun;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okCommitCnt  <= '0;
      errCommitCnt <= '0;
    end else begin
      if (strobes.commitOk)  okCommitCnt  <= okCommitCnt + 1'b1;
      if (strobes.commitErr) errCommitCnt <= errCommitCnt + 1'b1;
    end
  end

  // Sticky flags; set wins over clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      notHeldErr    <= 1'b0;
      rbMismatchErr <= 1'b0;
    end else begin
      if (holdViol)      notHeldErr <= 1'b1;
      else if (clrFlags) notHeldErr <= 1'b0;
      if (rbViol)        rbMismatchErr <= 1'b1;
      else if (clrFlags) rbMismatchErr <= 1'b0;
    end
  end

  // One shadow entry and one hit bit per register.
  for (genvar g = 0; g < NUM_REGS; g++) begin : gEntry
    logic [DATA_W-1:0] entryQ;
    logic              hitQ;
    logic              sel;

    assign sel = (wrIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ <= '0;
        hitQ   <= 1'b0;
      end else begin
        if (strobes.commitOk && sel) entryQ <= pwdata;
        if (anyCommit && sel)        hitQ   <= 1'b1;
      end
    end

    assign shadowVec[g] = entryQ;
    assign hitBits[g]   = hitQ;
  end

endmodule

// File: rtl/apb_wr_monitor.sv
module apb_wr_monitor
  import apb_wmon_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3,
  parameter int IDX_LSB = 2,
  parameter int WAIT_W  = 8,
  parameter int CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clrFlags,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  input  logic                  pready,
  input  logic                  pslverr,
  input  logic                  rbValid,
  input  logic [IDX_W-1:0]      rbIdx,
  input  logic [DATA_W-1:0]     rbData,
  input  logic [IDX_W-1:0]      peekIdx,
  output logic [DATA_W-1:0]     peekData,
  output logic                  notHeldErr,
  output logic                  seqErr,
  output logic                  rbMismatchErr,
  output logic [WAIT_W-1:0]     waitCnt,
  output logic                  waitCntValid,
  output logic [CNT_W-1:0]      okCommitCnt,
  output logic [CNT_W-1:0]      errCommitCnt,
  output logic [(1<<IDX_W)-1:0] hitBits
);

  monStrobes_t strobes;

  apb_wmon_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .clrFlags (clrFlags),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .pready   (pready),
    .pslverr  (pslverr),
    .strobes  (strobes),
    .seqErr   (seqErr)
  );

  apb_wmon_dp #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .IDX_W (IDX_W),
    .IDX_LSB(IDX_LSB), .WAIT_W (WAIT_W), .CNT_W (CNT_W)
  ) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .clrFlags      (clrFlags),
    .strobes       (strobes),
    .paddr         (paddr),
    .pwdata        (pwdata),
    .rbValid       (rbValid),
    .rbIdx         (rbIdx),
    .rbData        (rbData),
    .peekIdx       (peekIdx),
    .peekData      (peekData),
    .notHeldErr    (notHeldErr),
    .rbMismatchErr (rbMismatchErr),
    .waitCnt       (waitCnt),
    .waitCntValid  (waitCntValid),
    .okCommitCnt   (okCommitCnt),
    .errCommitCnt  (errCommitCnt),
    .hitBits       (hitBits)
  );

endmodule

// File: rtl/apb_wmon_chk.sv
module apb_wmon_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrFlags,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic              pready,
  input logic              pslverr,
  input logic [IDX_W-1:0]  peekIdx,
  input logic [DATA_W-1:0] peekData,
  input logic              notHeldErr,
  input logic              waitCntValid,
  input logic [CNT_W-1:0]  okCommitCnt,
  input logic [CNT_W-1:0]  errCommitCnt
);

  logic commitSeen;
  assign commitSeen = psel && penable && pwrite && pready;

  // R2
  err_commit_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitSeen && pslverr) |=> (!$stable(peekIdx) || $stable(peekData)));

  // R3
  wait_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psel && penable && pwrite && !pready) |=> (!$stable(peekIdx) || $stable(peekData)));

  // R4
  wait_report_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitSeen |=> waitCntValid);

  // R4
  wait_report_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitSeen |=> !waitCntValid);

  // R5
  ok_count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitSeen && !pslverr) |=> (okCommitCnt == CNT_W'($past(okCommitCnt) + 1'b1)));

  // R5
  err_count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(commitSeen && pslverr) |=> $stable(errCommitCnt));

  // R10
  held_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (notHeldErr && !clrFlags) |=> notHeldErr);

endmodule

bind apb_wr_monitor apb_wmon_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .clrFlags     (clrFlags),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .pready       (pready),
  .pslverr      (pslverr),
  .peekIdx      (peekIdx),
  .peekData     (peekData),
  .notHeldErr   (notHeldErr),
  .waitCntValid (waitCntValid),
  .okCommitCnt  (okCommitCnt),
  .errCommitCnt (errCommitCnt)
);

// File: tb/sim_apb_wr_monitor.sv
`timescale 1ns/1ps
module sim_apb_wr_monitor;

  localparam int DATA_W = 32, ADDR_W = 8, IDX_W = 3, IDX_LSB = 2;
  localparam int WAIT_W = 8, CNT_W = 16, NREG = 1 << IDX_W;
  localparam int NVEC = 8;

  // Stimulus table: address, data, wait states, error response.
  localparam logic [ADDR_W-1:0] V_ADDR [NVEC] = '{8'h00, 8'h04, 8'h04, 8'h1C, 8'h08, 8'h10, 8'h04, 8'h14};
  localparam logic [DATA_W-1:0] V_DATA [NVEC] = '{32'h11111111, 32'hA5A5A5A5, 32'hDEADBEEF, 32'h7E7E0001,
                                                  32'h0BADF00D, 32'h12345678, 32'h0000FFFF, 32'hCAFEF00D};
  localparam int                V_WAIT [NVEC] = '{0, 2, 0, 3, 1, 1, 0, 4};
  localparam logic              V_ERR  [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0, rstN = 1'b0, clrFlags = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pready = 1'b0, pslverr = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic rbValid = 1'b0;
  logic [IDX_W-1:0] rbIdx = '0, peekIdx = '0;
  logic [DATA_W-1:0] rbData = '0;
  logic [DATA_W-1:0] peekData;
  logic notHeldErr, seqErr, rbMismatchErr, waitCntValid;
  logic [WAIT_W-1:0] waitCnt;
  logic [CNT_W-1:0] okCommitCnt, errCommitCnt;
  logic [NREG-1:0] hitBits;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DATA_W-1:0] model [NREG];
  int okExp = 0, errExp = 0;
  logic [NREG-1:0] hitExp = '0;

  apb_wr_monitor #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
                   .WAIT_W(WAIT_W), .CNT_W(CNT_W)) u0 (.*);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One write transfer; glitchAt >= 0 flips pwdata in that wait iteration.
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                         input int waits, input logic err, input int glitchAt);
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] oldVal, commitData;
    idx = a[IDX_LSB +: IDX_W];
    oldVal = model[idx];
    commitData = (glitchAt >= 0 && glitchAt < waits) ? ~d : d;
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d; pready = 0; pslverr = 0; peekIdx = idx;
    @(negedge clk);
    penable = 1; pready = (waits == 0); pslverr = (waits == 0) ? err : 1'b0;
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      // R3: a not-ready cycle has just passed
      check(peekData == oldVal, "R3 shadow during wait", peekData, oldVal);
      if (w == glitchAt) pwdata = ~d;
      pready = (w == waits - 1);
      pslverr = (w == waits - 1) ? err : 1'b0;
    end
    @(negedge clk);
    psel = 0; penable = 0; pready = 0; pslverr = 0; pwrite = 0;
    hitExp[idx] = 1'b1;
    if (err) errExp++; else begin okExp++; model[idx] = commitData; end
    // R4
    check(waitCntValid == 1'b1, "R4 valid pulse", waitCntValid, 1);
    check(waitCnt == WAIT_W'(waits), "R4 wait count", waitCnt, waits);
    // R1 and R2
    check(peekData == model[idx], err ? "R2 errored commit" : "R1 commit update", peekData, model[idx]);
    // R5
    check(okCommitCnt == CNT_W'(okExp), "R5 ok count", okCommitCnt, okExp);
    check(errCommitCnt == CNT_W'(errExp), "R5 err count", errCommitCnt, errExp);
    @(negedge clk);
    check(waitCntValid == 1'b0, "R4 pulse ends", waitCntValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check({notHeldErr, seqErr, rbMismatchErr, waitCntValid} == 4'b0, "R10 reset flags",
          {notHeldErr, seqErr, rbMismatchErr, waitCntValid}, 0);
    check(okCommitCnt == 0 && errCommitCnt == 0, "R10 reset counters", okCommitCnt, 0);
    check(hitBits == 0, "R10 reset hit bits", hitBits, 0);
    check(peekData == 0, "R10 reset shadow", peekData, 0);

    for (int v = 0; v < NVEC; v++) doWrite(V_ADDR[v], V_DATA[v], V_WAIT[v], V_ERR[v], -1);

    // R9: indices 3 and 6 never written
    check(hitBits == hitExp, "R9 hit bits", hitBits, hitExp);
    // R6 and R7: clean traffic raises nothing
    check(notHeldErr == 1'b0, "R6 clean writes", notHeldErr, 0);
    check(seqErr == 1'b0, "R7 clean sequencing", seqErr, 0);

    // R6: data moves during the second access cycle
    doWrite(8'h0C, 32'h00000055, 2, 1'b0, 0);
    check(notHeldErr == 1'b1, "R6 data not held", notHeldErr, 1);
    check(hitBits == hitExp, "R9 hit after index 3", hitBits, hitExp);
    doWrite(8'h18, 32'h66666666, 1, 1'b0, -1);
    check(notHeldErr == 1'b1, "R10 sticky hold flag", notHeldErr, 1);
    @(negedge clk) clrFlags = 1;
    @(negedge clk) clrFlags = 0;
    check(notHeldErr == 1'b0, "R10 clear hold flag", notHeldErr, 0);

    // R7: access with no setup
    @(negedge clk); psel = 1; penable = 1; pwrite = 0; pready = 1; paddr = 8'h00;
    @(negedge clk); psel = 0; penable = 0; pready = 0;
    check(seqErr == 1'b1, "R7 access without setup", seqErr, 1);
    check(okCommitCnt == CNT_W'(okExp), "R5 read access ignored", okCommitCnt, okExp);
    @(negedge clk) clrFlags = 1;
    @(negedge clk) clrFlags = 0;
    check(seqErr == 1'b0, "R10 clear seq flag", seqErr, 0);

    // R8: matching then mismatching read-back
    @(negedge clk); rbValid = 1; rbIdx = 3'd1; rbData = model[1];
    @(negedge clk); rbValid = 0;
    check(rbMismatchErr == 1'b0, "R8 matching read-back", rbMismatchErr, 0);
    @(negedge clk); rbValid = 1; rbIdx = 3'd2; rbData = 32'h0BADF00D;
    @(negedge clk); rbValid = 0;
    check(rbMismatchErr == 1'b1, "R8 errored write read back", rbMismatchErr, 1);

    // R10: reset mid-run
    @(negedge clk); rstN = 0; peekIdx = 3'd1;
    #1;
    check(rbMismatchErr == 1'b0 && okCommitCnt == 0 && errCommitCnt == 0, "R10 reset flags and counts",
          {rbMismatchErr, okCommitCnt}, 0);
    check(hitBits == 0 && peekData == 0, "R10 reset shadow and hits", {hitBits, peekData}, 0);
    @(negedge clk); rstN = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule